// File: doc/BRIEF.md
# Factory Bad-Block Table Expander

This block turns the factory bad-block bitmap of a flash device into the controller's in-memory bad-block table. The bitmap arrives as a byte stream with a valid/ready handshake. Each bit stands for one erase block, and a clear bit means the block is bad. The table is a single-port RAM of packed bytes. Each byte holds four 2-bit entries, and an entry of `11` marks a bad block. For every bad block the expander reads the table byte that holds its entry, ORs `11` into that entry, and writes the byte back. It also counts the bad blocks it finds.

A pass begins with a `start` pulse. Two error flags come with the pulse and say whether the ECC check failed on the primary copy of the bitmap and on the redundant copy. The block reports which copy's page the upstream reader must stream:

- The primary copy is used when its ECC check passed.
- The redundant copy is used only when the primary copy failed.
- When both copies failed, no bytes are taken, the table is left alone, and a warning is raised.

Top module: `bbt_expander`

## Requirements
- R1: After reset, `in_ready`, `done`, `warn` and `bad_count` are all 0, and the block issues no table read or write.
- R2: A clear bit at position b (0 = least significant) of stream byte i marks block 8*i + 7 - b as bad. A set bit leaves that block's entry untouched.
- R3: For a bad block n, bits [2*(n%4)+1 : 2*(n%4)] of table byte n/4 become `11`. Every other bit of that byte keeps its previous value.
- R4: Each table update is a read followed, in the very next cycle, by a write to the same address. The read data arrives one cycle after `tbl_rd_en`. Read and write are never asserted together. A table byte whose four blocks are all good gets no access at all.
- R5: `bad_count` is cleared when a pass is accepted and then rises by exactly one for each bad block found in that pass.
- R6: `done` is high for exactly one cycle, after the update caused by the last bitmap byte. `in_ready` is low from then on until the next pass.
- R7: When the primary flag is clear, `src_page` equals PRIMARY_PAGE (default 16) and `use_backup` is 0. When the primary flag is set and the redundant flag is clear, `src_page` equals BACKUP_PAGE (default 24) and `use_backup` is 1.
- R8: When both flags are set at `start`, the pass does the following:
  - It accepts no byte and makes no table access.
  - It leaves `bad_count` at 0.
  - It sets `warn`, which stays set until the next accepted start.
  - It still pulses `done`.
- R9: A `start` pulse while a pass is running is ignored. The running pass finishes with its own source selection and its own results.
- R10: The block takes exactly NUM_BLOCKS/8 bytes per pass. An all-ones byte produces no table access. An all-zero byte marks all eight of its blocks bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a pass when the block is idle |
| pri_ecc_fail | input | 1 | ECC check of the primary bitmap copy failed (sampled at start) |
| bak_ecc_fail | input | 1 | ECC check of the redundant bitmap copy failed (sampled at start) |
| src_page | output | PAGE_W | Page the upstream reader must stream |
| use_backup | output | 1 | The redundant copy is selected |
| in_valid | input | 1 | Bitmap byte valid |
| in_ready | output | 1 | Block accepts a bitmap byte |
| in_data | input | 8 | Bitmap byte |
| tbl_addr | output | log2(NUM_BLOCKS/4) | Table RAM byte address |
| tbl_rd_en | output | 1 | Table RAM read strobe |
| tbl_rdata | input | 8 | Table RAM read data, valid one cycle after the read strobe |
| tbl_wr_en | output | 1 | Table RAM write strobe |
| tbl_wdata | output | 8 | Table RAM write data |
| bad_count | output | log2(NUM_BLOCKS+1) | Bad blocks found in the current pass |
| done | output | 1 | One-cycle end-of-pass pulse |
| warn | output | 1 | Both copies failed, so the table was not updated |

## Verification
The bench builds the block with NUM_BLOCKS = 64, which gives an 8-byte bitmap and a 16-byte table. The last-byte boundary, the all-good and all-bad extremes and a fully populated table are then all reached in a few hundred cycles. The bench keeps the default page numbers 16 and 24, so the source selection is checked against the actual values. Starting from a table already holding scattered `11` entries shows whether the update keeps the neighbouring entries untouched.

// File: rtl/bbt_expander.sv
module bbt_expander #(
  parameter int NUM_BLOCKS   = 512,
  parameter int PAGE_W       = 16,
  parameter int PRIMARY_PAGE = 16,
  parameter int BACKUP_PAGE  = 24,
  localparam int BMP_BYTES   = NUM_BLOCKS / 8,
  localparam int TBL_DEPTH   = NUM_BLOCKS / 4,
  localparam int IDX_W       = $clog2(BMP_BYTES),
  localparam int AW          = $clog2(TBL_DEPTH),
  localparam int CNT_W       = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pri_ecc_fail,
  input  logic              bak_ecc_fail,
  output logic [PAGE_W-1:0] src_page,
  output logic              use_backup,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic [AW-1:0]     tbl_addr,
  output logic              tbl_rd_en,
  input  logic [7:0]        tbl_rdata,
  output logic              tbl_wr_en,
  output logic [7:0]        tbl_wdata,
  output logic [CNT_W-1:0]  bad_count,
  output logic              done,
  output logic              warn
);

  typedef enum logic [2:0] {S_IDLE, S_TAKE, S_SCAN, S_WRITE, S_FIN} state_t;

  state_t           state;
  logic [7:0]       inv_q;
  logic [IDX_W-1:0] byte_idx;
  logic             half;
  logic             alt_q;
  logic             warn_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       nib;
  logic [7:0]       mask;
  logic [2:0]       nib_bad;
  logic             last_byte;

  assign nib       = half ? inv_q[3:0] : inv_q[7:4];
  assign nib_bad   = {2'b0, nib[0]} + {2'b0, nib[1]} + {2'b0, nib[2]} + {2'b0, nib[3]};
  assign last_byte = (byte_idx == IDX_W'(BMP_BYTES - 1));

  for (genvar k = 0; k < 4; k++) begin : g_mask
    assign mask[2*k +: 2] = {2{nib[3-k]}};
  end

  assign tbl_addr   = {byte_idx, half};
  assign tbl_rd_en  = (state == S_SCAN) && (mask != 8'h00);
  assign tbl_wr_en  = (state == S_WRITE);
  assign tbl_wdata  = tbl_rdata | mask;
  assign in_ready   = (state == S_TAKE);
  assign done       = (state == S_FIN);
  assign warn       = warn_q;
  assign bad_count  = cnt_q;
  assign use_backup = alt_q;
  assign src_page   = alt_q ? PAGE_W'(BACKUP_PAGE) : PAGE_W'(PRIMARY_PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      inv_q    <= '0;
      byte_idx <= '0;
      half     <= 1'b0;
      alt_q    <= 1'b0;
      warn_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          cnt_q    <= '0;
          alt_q    <= pri_ecc_fail;
          byte_idx <= '0;
          half     <= 1'b0;
          warn_q   <= pri_ecc_fail && bak_ecc_fail;
          state    <= (pri_ecc_fail && bak_ecc_fail) ? S_FIN : S_TAKE;
        end
        S_TAKE: if (in_valid) begin
          inv_q <= ~in_data;
          half  <= 1'b0;
          state <= S_SCAN;
        end
        S_SCAN, S_WRITE: begin
          if (state == S_WRITE) cnt_q <= cnt_q + CNT_W'(nib_bad);
          if (state == S_SCAN && mask != 8'h00) begin
            state <= S_WRITE;
          end else if (!half) begin
            half  <= 1'b1;
            state <= S_SCAN;
          end else if (last_byte) begin
            state <= S_FIN;
          end else begin
            byte_idx <= byte_idx + 1'b1;
            state    <= S_TAKE;
          end
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: a write always follows a read of the same byte
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |-> ($past(tbl_rd_en) && $past(tbl_addr) == tbl_addr));

  a_r4_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tbl_rd_en && tbl_wr_en));

  // R3: every changed entry goes to 11, and no bit is cleared
  a_r3_entries_only_set: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |-> (((tbl_wdata & tbl_rdata) == tbl_rdata) &&
                   ((tbl_wdata ^ tbl_rdata) & 8'h55) == (((tbl_wdata ^ tbl_rdata) >> 1) & 8'h55)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(state == S_IDLE) && $past(start)) |-> (cnt_q >= $past(cnt_q)));

  a_r8_warn_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> (!in_ready && !tbl_rd_en && !tbl_wr_en));

  a_r9_source_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(alt_q));

endmodule

// File: tb/bbt_expander_bench.sv
module bbt_expander_bench;
  localparam int NB  = 64;
  localparam int NBY = NB / 8;
  localparam int TD  = NB / 4;
  localparam int AW  = $clog2(TD);
  localparam int CW  = $clog2(NB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pri_f = 1'b0, bak_f = 1'b0;
  logic [15:0] src_page;
  logic use_backup, in_valid = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic [AW-1:0] tbl_addr;
  logic tbl_rd_en, tbl_wr_en;
  logic [7:0] tbl_rdata = 8'h00, tbl_wdata;
  logic [CW-1:0] bad_count;
  logic done, warn;

  int checks = 0, errors = 0, writes = 0;
  logic [7:0] ram [TD];
  logic [7:0] pre [TD];
  logic [7:0] expmask [TD];
  logic [7:0] bmp [NBY];

  always #2 clk = ~clk;

  bbt_expander #(.NUM_BLOCKS(NB)) u_bbt_expander (
    .clk(clk), .rst_n(rst_n), .start(start), .pri_ecc_fail(pri_f), .bak_ecc_fail(bak_f),
    .src_page(src_page), .use_backup(use_backup), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tbl_addr(tbl_addr), .tbl_rd_en(tbl_rd_en), .tbl_rdata(tbl_rdata),
    .tbl_wr_en(tbl_wr_en), .tbl_wdata(tbl_wdata), .bad_count(bad_count), .done(done), .warn(warn));

  always @(posedge clk) begin
    if (tbl_rd_en) tbl_rdata <= ram[tbl_addr];
    if (tbl_wr_en) ram[tbl_addr] <= tbl_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tbl_rd_en && tbl_wr_en) chk(1'b0, "R4 read and write together", 1, 0);
      if (tbl_wr_en) begin
        writes++;
        chk(tbl_wdata == (ram[tbl_addr] | expmask[tbl_addr]), "R3 write data",
            tbl_wdata, ram[tbl_addr] | expmask[tbl_addr]);
      end
    end
  end

  task automatic run_pass(input logic pb, input logic bb, input int gap, input bit poke);
    int expcnt = 0;
    int expwr = 0;
    int wait_n = 0;
    bit skip = pb && bb;
    for (int a = 0; a < TD; a++) expmask[a] = 8'h00;
    if (!skip) begin
      for (int i = 0; i < NBY; i++) begin
        logic [7:0] inv = ~bmp[i];
        for (int k = 0; k < 8; k++) begin
          if (inv[7-k]) begin
            int blk = 8*i + k;
            expmask[blk/4] = expmask[blk/4] | (8'h03 << ((blk % 4) * 2));
            expcnt++;
          end
        end
      end
    end
    for (int a = 0; a < TD; a++) begin
      pre[a] = ram[a];
      if (expmask[a] != 8'h00) expwr++;
    end
    writes = 0;
    @(negedge clk); start = 1'b1; pri_f = pb; bak_f = bb;
    @(negedge clk); start = 1'b0;
    chk(src_page == (pb ? 16'd24 : 16'd16), "R7 source page", src_page, pb ? 24 : 16);
    chk(use_backup == pb, "R7 backup select", use_backup, pb);
    if (!skip) begin
      for (int i = 0; i < NBY; i++) begin
        repeat (gap) @(negedge clk);
        in_valid = 1'b1; in_data = bmp[i];
        wait_n = 0;
        while (!in_ready && wait_n < 100) begin @(negedge clk); wait_n++; end
        @(negedge clk);
        in_valid = 1'b0;
        if (poke && i == 1) begin
          start = 1'b1; pri_f = 1'b1; bak_f = 1'b1;
          @(negedge clk); start = 1'b0; pri_f = pb; bak_f = bb;
        end
      end
    end
    wait_n = 0;
    while (!done && wait_n < 2000) begin @(negedge clk); wait_n++; end
    chk(done == 1'b1, "R6 done pulse seen", done, 1);
    chk(bad_count == CW'(expcnt), "R5 bad count", bad_count, expcnt);
    chk(warn == skip, "R8 warn flag", warn, skip);
    @(negedge clk);
    chk(done == 1'b0, "R6 done lasts one cycle", done, 0);
    chk(in_ready == 1'b0, "R6 ready low after pass", in_ready, 0);
    chk(src_page == (pb ? 16'd24 : 16'd16), "R9 source kept", src_page, pb ? 24 : 16);
    chk(writes == expwr, "R4 R10 table write count", writes, expwr);
    for (int a = 0; a < TD; a++)
      chk(ram[a] == (pre[a] | expmask[a]), "R2 R3 table entry", ram[a], pre[a] | expmask[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < TD; a++) ram[a] = ((a % 3) == 0) ? 8'h30 : 8'h00;
    for (int a = 0; a < TD; a++) expmask[a] = 8'h00;
    repeat (3) @(negedge clk);
    chk({in_ready, done, warn} == 3'b000, "R1 reset outputs", {in_ready, done, warn}, 0);
    chk(bad_count == '0, "R1 reset count", bad_count, 0);
    chk(!tbl_rd_en && !tbl_wr_en, "R1 no table access", {tbl_rd_en, tbl_wr_en}, 0);
    rst_n = 1'b1;

    bmp = '{8'hFF, 8'h7F, 8'hFE, 8'hA5, 8'hFF, 8'h0F, 8'hF0, 8'hEF};
    run_pass(1'b0, 1'b0, 0, 1'b0);              // R2 R3 R7 primary
    bmp = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00};
    run_pass(1'b1, 1'b0, 2, 1'b0);              // R7 backup, R10 last byte
    run_pass(1'b1, 1'b1, 0, 1'b0);              // R8 both failed
    bmp = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_pass(1'b0, 1'b0, 1, 1'b0);              // R10 no bad blocks
    bmp = '{8'hDB, 8'h3C, 8'h81, 8'h66, 8'hFE, 8'h7F, 8'hBD, 8'hC3};
    run_pass(1'b0, 1'b0, 0, 1'b1);              // R9 start ignored mid-pass
    bmp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_pass(1'b1, 1'b0, 3, 1'b0);              // R5 R10 every block bad
    for (int a = 0; a < TD; a++) chk(ram[a] == 8'hFF, "R10 full table", ram[a], 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule